// File: doc/BRIEF.md
# Receive Interrupt Coalescing Timer

This block reduces the interrupt rate of a receive DMA ring. It counts frame-completion pulses and raises one interrupt request in two cases. The first is when the number of frames waiting reaches a programmed count. The second is when a programmed idle time has passed since the first waiting frame arrived. Software clears the request with an acknowledge pulse, and that pulse also starts a new interval.

The idle time is measured in coarse ticks. Each tick is `TICK_DIV` cycles of the block clock, 1024 by default, which is about 8.192 µs at 125 MHz. A typical setting is 10 frames with 7 ticks (about 57 µs).

A timeout field of zero turns the timer path off, and only the frame count then raises the interrupt. The count threshold is clamped when it is written. The timeout field sits inside a wider register, and a write changes only that field.

Top module: `rxmod_irq_coalescer`

## Requirements
- R1: After reset the interrupt is low, the threshold reads 1, the timeout field is 0, and the bits outside the field read the parameter value (default 0x00A50000).
- R2: A threshold write of 0 is stored as 1, a write above 255 is stored as 255, and any value in between is stored unchanged (`THR_W` = 8).
- R3: A timeout write takes only bits [15:0] of the write data. The stored bits outside [15:0] keep their previous value.
- R4: Each frame pulse adds one to the pending count. The interrupt goes high on the second clock edge after the frame pulse that brings the pending count to the threshold, and not earlier.
- R5: Once high, the interrupt stays high until it is acknowledged, whatever frames arrive in the meantime.
- R6: An acknowledge clears the interrupt and the pending count on the next edge. A frame pulse in the same cycle as the acknowledge counts as the first frame of the next interval.
- R7: With a timeout field N > 0 and at least one frame pending, the interrupt rises after the N-th tick. That is at least (N-1)·TICK_DIV+2 and at most N·TICK_DIV+1 cycles after the edge where the pending count left zero.
- R8: With a timeout field of 0, no wait, however long, raises the interrupt; only the count threshold does.
- R9: An acknowledge restarts the timeout. A frame taken in the acknowledge cycle gets a full new timeout window.
- R10: While no frame is pending, the timer never raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; ticks are derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle pulse per completed receive frame |
| irq_ack | input | 1 | Software acknowledge; clears the interrupt and pending state |
| thr_we | input | 1 | Write strobe for the frame-count threshold |
| thr_wdata | input | 32 | Threshold write value, clamped to 1..255 |
| tmo_we | input | 1 | Write strobe for the timeout register |
| tmo_wdata | input | 32 | Timeout register write data; only bits [15:0] are taken |
| irq | output | 1 | Interrupt request, held until acknowledged |
| thr_q | output | 8 | Stored threshold |
| tmo_reg | output | 32 | Full timeout register |

## Verification
Register writes are visible one edge after the strobe. The bench therefore reads them back at the falling edge right after the write cycle. The count interrupt is due two edges after the frame pulse that reaches the threshold. The checks sample the interrupt low at the first falling edge after that pulse and high at the next one.

The tick prescaler runs freely, so the timer result can land anywhere within a window one tick wide. Timeout checks confirm the interrupt is still low just before the earliest edge it may rise on. They then poll up to a bound past the latest allowed edge. Acknowledge checks sample the falling edge after the acknowledge cycle, and again one edge later, to catch a pending count that was not cleared.

// File: rtl/rxmod_pkg.sv
package rxmod_pkg;
  localparam int unsigned REG_W = 32;

  // Clamp a value into [lo, hi].
  function automatic logic [REG_W-1:0] clamp_range(logic [REG_W-1:0] v,
                                                   logic [REG_W-1:0] lo,
                                                   logic [REG_W-1:0] hi);
    logic [REG_W-1:0] r;
    r = v;
    if (v < lo) r = lo;
    if (v > hi) r = hi;
    return r;
  endfunction

  // Mask with ones in [lsb, lsb+w).
  function automatic logic [REG_W-1:0] field_mask(int unsigned lsb, int unsigned w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < REG_W; i++)
      if (i >= lsb && i < lsb + w) m[i] = 1'b1;
    return m;
  endfunction

  // Replace the masked bits of old with those of wr.
  function automatic logic [REG_W-1:0] merge_field(logic [REG_W-1:0] old,
                                                   logic [REG_W-1:0] wr,
                                                   logic [REG_W-1:0] fmask);
    return (old & ~fmask) | (wr & fmask);
  endfunction
endpackage

// File: rtl/rxmod_tick_gen.sv
module rxmod_tick_gen #(
  parameter int unsigned TICK_DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_bypass
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] pre_q;
      logic             wrap;
      assign wrap = (pre_q == DIV_W'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= wrap ? '0 : pre_q + 1'b1;
      end
      assign tick = wrap;

      // R7
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rxmod_cfg_regs.sv
module rxmod_cfg_regs
  import rxmod_pkg::*;
#(
  parameter int unsigned THR_W   = 8,
  parameter int unsigned TMO_LSB = 0,
  parameter int unsigned TMO_W   = 16,
  parameter logic [REG_W-1:0] TMO_RST = 32'h00A5_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_we,
  input  logic [REG_W-1:0] thr_wdata,
  input  logic             tmo_we,
  input  logic [REG_W-1:0] tmo_wdata,
  output logic [THR_W-1:0] thr_q,
  output logic [REG_W-1:0] tmo_reg,
  output logic [TMO_W-1:0] tmo_ticks
);
  localparam logic [REG_W-1:0] THR_MAX  = REG_W'((64'd1 << THR_W) - 64'd1);
  localparam logic [REG_W-1:0] TMO_MASK = field_mask(TMO_LSB, TMO_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= THR_W'(1);
    else if (thr_we) thr_q <= THR_W'(clamp_range(thr_wdata, REG_W'(1), THR_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_reg <= TMO_RST & ~TMO_MASK;
    else if (tmo_we) tmo_reg <= merge_field(tmo_reg, tmo_wdata, TMO_MASK);
  end

  assign tmo_ticks = tmo_reg[TMO_LSB +: TMO_W];

  // R2
  thr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q != '0);
  // R3
  tmo_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(tmo_reg & ~TMO_MASK));
  // R3
  tmo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_we |=> tmo_ticks == $past(tmo_wdata[TMO_LSB +: TMO_W]));
endmodule

// File: rtl/rxmod_pend_ctr.sv
module rxmod_pend_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic             ack,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] pend_q,
  output logic             pend_nz,
  output logic             cnt_hit
);
  localparam logic [CNT_W-1:0] PEND_MAX = '1;

  function automatic logic [CNT_W-1:0] pend_next(logic [CNT_W-1:0] cur,
                                                 logic fr, logic clr);
    if (clr)                     return fr ? CNT_W'(1) : '0;
    if (fr && cur != PEND_MAX)   return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_next(pend_q, frame_done, ack);
  end

  assign pend_nz = (pend_q != '0);
  assign cnt_hit = pend_nz && (pend_q >= thr);

  // R4
  pend_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !ack && pend_q != PEND_MAX) |=> pend_q == $past(pend_q) + 1'b1);
  // R6
  pend_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> pend_q == CNT_W'($past(frame_done)));
endmodule

// File: rtl/rxmod_tmo_timer.sv
module rxmod_tmo_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pend_nz,
  input  logic             ack,
  input  logic [TMO_W-1:0] tmo_ticks,
  output logic [TMO_W-1:0] tmo_cnt,
  output logic             tmo_hit
);
  logic tmo_en;
  assign tmo_en = (tmo_ticks != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             tmo_cnt <= '0;
    else if (ack || !pend_nz)               tmo_cnt <= '0;
    else if (tick && tmo_cnt < tmo_ticks)   tmo_cnt <= tmo_cnt + 1'b1;
  end

  assign tmo_hit = tmo_en && pend_nz && (tmo_cnt >= tmo_ticks);

  // R7
  tmo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_nz && !ack && tmo_cnt < tmo_ticks) |=> tmo_cnt == $past(tmo_cnt) + 1'b1);
  // R9
  tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> tmo_cnt == '0);
  // R10
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_nz |=> tmo_cnt == '0);
endmodule

// File: rtl/rxmod_irq_coalescer.sv
module rxmod_irq_coalescer
  import rxmod_pkg::*;
#(
  parameter int unsigned THR_W    = 8,
  parameter int unsigned TMO_LSB  = 0,
  parameter int unsigned TMO_W    = 16,
  parameter int unsigned TICK_DIV = 1024,
  parameter logic [31:0] TMO_RST  = 32'h00A5_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic             irq_ack,
  input  logic             thr_we,
  input  logic [31:0]      thr_wdata,
  input  logic             tmo_we,
  input  logic [31:0]      tmo_wdata,
  output logic             irq,
  output logic [THR_W-1:0] thr_q,
  output logic [31:0]      tmo_reg
);
  logic             tick;
  logic [TMO_W-1:0] tmo_ticks;
  logic [TMO_W-1:0] tmo_cnt;
  logic [THR_W-1:0] pend_q;
  logic             pend_nz;
  logic             cnt_hit;
  logic             tmo_hit;
  logic             irq_q;

  rxmod_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  rxmod_cfg_regs #(.THR_W(THR_W), .TMO_LSB(TMO_LSB), .TMO_W(TMO_W),
                   .TMO_RST(TMO_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .tmo_we(tmo_we), .tmo_wdata(tmo_wdata), .thr_q(thr_q),
    .tmo_reg(tmo_reg), .tmo_ticks(tmo_ticks));

  rxmod_pend_ctr #(.CNT_W(THR_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .ack(irq_ack),
    .thr(thr_q), .pend_q(pend_q), .pend_nz(pend_nz), .cnt_hit(cnt_hit));

  rxmod_tmo_timer #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pend_nz(pend_nz),
    .ack(irq_ack), .tmo_ticks(tmo_ticks), .tmo_cnt(tmo_cnt),
    .tmo_hit(tmo_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_ack) irq_q <= 1'b0;
    else              irq_q <= irq_q | cnt_hit | tmo_hit;
  end

  assign irq = irq_q;

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack) |=> irq_q);
  // R6
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_q);
  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(cnt_hit || tmo_hit));
  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !pend_nz) |=> !irq_q);
endmodule

// File: tb/rxmod_irq_coalescer_tb.sv
module rxmod_irq_coalescer_tb;
  localparam int DIV = 1024;
  logic clk = 0;
  logic rst_n = 0;
  logic frame_done = 0, irq_ack = 0, thr_we = 0, tmo_we = 0;
  logic [31:0] thr_wdata = 0, tmo_wdata = 0;
  logic irq;
  logic [7:0] thr_q;
  logic [31:0] tmo_reg;
  int vectors = 0, errs = 0;

  always #2.5 clk = ~clk;

  rxmod_irq_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .irq_ack(irq_ack),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .tmo_we(tmo_we),
    .tmo_wdata(tmo_wdata), .irq(irq), .thr_q(thr_q), .tmo_reg(tmo_reg));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_thr(logic [31:0] v);
    @(negedge clk); thr_we = 1; thr_wdata = v;
    @(negedge clk); thr_we = 0;
  endtask

  task automatic write_tmo(logic [31:0] v);
    @(negedge clk); tmo_we = 1; tmo_wdata = v;
    @(negedge clk); tmo_we = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
  endtask

  task automatic do_ack(logic with_frame);
    @(negedge clk); irq_ack = 1; frame_done = with_frame;
    @(negedge clk); irq_ack = 0; frame_done = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll_irq(int max, output logic seen);
    seen = 0;
    for (int i = 0; i < max && !seen; i++) begin
      @(negedge clk);
      seen = irq;
    end
  endtask

  task automatic t_reset();
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 thr", {24'd0, thr_q}, 32'd1);
    check("R1 tmo_reg", tmo_reg, 32'h00A5_0000);
  endtask

  task automatic t_thr_clamp();
    write_thr(32'd0);   check("R2 zero->1", {24'd0, thr_q}, 32'd1);
    write_thr(32'd300); check("R2 300->255", {24'd0, thr_q}, 32'd255);
    write_thr(32'd10);  check("R2 10 kept", {24'd0, thr_q}, 32'd10);
  endtask

  task automatic t_tmo_field();
    write_tmo(32'hFFFF_0007); check("R3 field only", tmo_reg, 32'h00A5_0007);
    write_tmo(32'h1234_0000); check("R3 upper kept", tmo_reg, 32'h00A5_0000);
  endtask

  task automatic t_count_thresh();
    write_thr(3); write_tmo(0);
    pulse_frame(); idle(2); check("R4 1 of 3", {31'd0, irq}, 0);
    pulse_frame(); idle(2); check("R4 2 of 3", {31'd0, irq}, 0);
    pulse_frame(); check("R4 not early", {31'd0, irq}, 0);
    idle(1); check("R4 threshold irq", {31'd0, irq}, 1);
  endtask

  task automatic t_hold_ack();
    pulse_frame(); pulse_frame(); idle(10);
    check("R5 held", {31'd0, irq}, 1);
    do_ack(0); check("R6 ack clears", {31'd0, irq}, 0);
    idle(5); check("R6 pending cleared", {31'd0, irq}, 0);
  endtask

  task automatic t_ack_same_cycle();
    write_thr(2);
    pulse_frame(); idle(2); check("R6 one of two", {31'd0, irq}, 0);
    do_ack(1); check("R6 ack+frame irq low", {31'd0, irq}, 0);
    idle(1); check("R6 old count dropped", {31'd0, irq}, 0);
    pulse_frame(); idle(1); check("R6 frame carried", {31'd0, irq}, 1);
    do_ack(0);
    write_thr(1);
    do_ack(1); check("R6 thr1 after ack", {31'd0, irq}, 0);
    idle(1); check("R6 thr1 reassert", {31'd0, irq}, 1);
    do_ack(0);
  endtask

  task automatic t_timeout_off();
    write_thr(5); write_tmo(0);
    pulse_frame(); idle(3000);
    check("R8 no timer irq", {31'd0, irq}, 0);
    repeat (4) pulse_frame();
    idle(1); check("R8 count still works", {31'd0, irq}, 1);
    do_ack(0);
  endtask

  task automatic t_idle();
    write_thr(255); write_tmo(1);
    idle(2200); check("R10 no frames no irq", {31'd0, irq}, 0);
  endtask

  task automatic t_timeout();
    logic seen;
    write_tmo(3);
    pulse_frame(); idle(2 * DIV - 4);
    check("R7 not before window", {31'd0, irq}, 0);
    poll_irq(DIV + 80, seen);
    check("R7 timeout irq", {31'd0, seen}, 1);
    do_ack(0); check("R7 ack", {31'd0, irq}, 0);
  endtask

  task automatic t_restart();
    logic seen;
    write_tmo(2);
    pulse_frame(); poll_irq(2 * DIV + 60, seen);
    check("R9 first timeout", {31'd0, seen}, 1);
    do_ack(1); check("R9 ack low", {31'd0, irq}, 0);
    idle(DIV - 8); check("R9 window restarted", {31'd0, irq}, 0);
    poll_irq(2 * DIV + 60, seen);
    check("R9 second timeout", {31'd0, seen}, 1);
    do_ack(0); idle(2200);
    check("R10 after clear", {31'd0, irq}, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_thr_clamp();
    t_tmo_field();
    t_count_thresh();
    t_hold_ack();
    t_ack_same_cycle();
    t_timeout_off();
    t_idle();
    t_timeout();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule